// File: doc/BRIEF.md
# Hotplug Event Register Block

This block holds the register state that software uses to learn about slot insertions and removals. A 16-bit event status register and a 16-bit event enable register are reached one byte at a time through a small byte window. A separate 32-bit window holds two slot bitmaps: one marks the slot that was just inserted, the other the slot that was just removed. A third write-only register takes a one-hot slot mask from software and turns it into an eject request carrying a slot number.

Hotplug events arrive on a valid/ready stream input that carries a slot number and an insert/remove flag. The ready signal is always high. The block never applies back-pressure and takes one event on every cycle in which valid is high. Each event wipes both bitmaps, sets the one bit for the event's slot in the correct map, and latches the hotplug bit in the status register. When the hotplug enable bit is set, the event also raises a one-cycle interrupt pulse. The eject request output is a one-cycle strobe that the consumer must take. It has no ready signal.

Register writes take effect at the clock edge. Register reads are combinational from the current state.

Top module: `hotplug_event_block`

## Requirements
- R1: After reset, every register reads 0. In the byte window, offset 0 returns status bits 7:0, offset 1 returns status bits 15:8, offset 2 returns enable bits 7:0 and offset 3 returns enable bits 15:8.
- R2: A byte write to status offset 0 or 1 clears each bit of that byte that is written as 1. The other status byte keeps its value.
- R3: A byte write to enable offset 2 or 3 replaces only that byte. The enable register does not change in any cycle without such a write.
- R4: Byte-window offsets 4 to 7 read 0, and writes to them change nothing. Slot-window offsets other than 0 and 4 read 0, and writes to them change nothing.
- R5: Slot-window offset 0 is the 32-bit inserted-slot bitmap and offset 4 is the 32-bit removed-slot bitmap. Both can be written and read back.
- R6: An accepted event zeroes both bitmaps. It then sets status bit 1 and sets bit [slot] of the inserted map when the insert flag is 1, or of the removed map when the flag is 0.
- R7: When enable bit 1 is set in the cycle an event is accepted, the interrupt output is high for exactly the next cycle. Otherwise the interrupt stays low.
- R8: A write of a nonzero value to the eject register raises the eject strobe for the next cycle only. The strobe carries the index of the lowest set bit of the written value. Reads of the eject register return 0.
- R9: A write of zero to the eject register produces no eject strobe.
- R10: When an event and a register write fall in the same cycle, the event takes priority. A status write that clears bit 1 still leaves bit 1 set, and a bitmap write is overridden by the event's bitmap update.
- R11: Event ready is high in every cycle, reset included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gpe_addr | input | 3 | Byte-window offset |
| gpe_we | input | 1 | Byte-window write strobe |
| gpe_wdata | input | 8 | Byte-window write data |
| gpe_rdata | output | 8 | Byte-window read data |
| map_addr | input | 3 | Slot-window byte offset |
| map_we | input | 1 | Slot-window write strobe |
| map_wdata | input | 32 | Slot-window write data |
| map_rdata | output | 32 | Slot-window read data |
| ej_we | input | 1 | Eject register write strobe |
| ej_wdata | input | 32 | Eject register write data (slot mask) |
| ej_rdata | output | 32 | Eject register read data, always 0 |
| evt_valid | input | 1 | Hotplug event valid |
| evt_ready | output | 1 | Hotplug event ready, always 1 |
| evt_slot | input | 5 | Slot number of the event |
| evt_insert | input | 1 | 1 = insertion, 0 = removal |
| irq_pulse | output | 1 | One-cycle interrupt pulse |
| eject_valid | output | 1 | One-cycle eject request strobe |
| eject_slot | output | 5 | Slot number of the eject request |

## Verification
Two functions can land on the same clock edge: an incoming hotplug event and a software write to the status byte or to a bitmap. The bench provokes both collisions. It drives an event together with a write-1-to-clear of status bit 1, and it drives an event together with an all-ones write to the inserted map. It then reads the registers back. It judges the result against the rule that the event wins: bit 1 stays set, and the map holds only the event's slot bit.

// File: rtl/hpg_pkg.sv
package hpg_pkg;
  localparam int unsigned SLOTS     = 32;
  localparam int unsigned SLOT_W    = $clog2(SLOTS);
  localparam int unsigned REG_BYTES = 2;
  localparam int unsigned GPE_AW    = 3;
  localparam int unsigned MAP_AW    = 3;
  localparam int unsigned HP_BIT    = 1;
  localparam logic [MAP_AW-1:0] UP_OFF = 3'd0;
  localparam logic [MAP_AW-1:0] DN_OFF = 3'd4;

  typedef enum logic [1:0] {
    WIN_STATUS = 2'd0,
    WIN_ENABLE = 2'd1,
    WIN_NONE   = 2'd2
  } gpe_win_e;
endpackage

// File: rtl/hpg_event_regs.sv
module hpg_event_regs
  import hpg_pkg::*;
#(
  parameter int unsigned BYTES = REG_BYTES,
  parameter int unsigned AW    = GPE_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr,
  input  logic              we,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              hp_set,
  output logic [BYTES*8-1:0] en_q
);
  localparam int unsigned W     = BYTES * 8;
  localparam int unsigned IDX_W = $clog2(BYTES);

  logic [W-1:0]     sts_q;
  logic [IDX_W-1:0] bidx;
  gpe_win_e         win;

  assign bidx = addr[IDX_W-1:0];

  always_comb begin
    case (addr >> IDX_W)
      0:       win = WIN_STATUS;
      1:       win = WIN_ENABLE;
      default: win = WIN_NONE;
    endcase
  end

  always_comb begin
    case (win)
      WIN_STATUS: rdata = sts_q[bidx*8 +: 8];
      WIN_ENABLE: rdata = en_q[bidx*8 +: 8];
      default:    rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q <= '0;
      en_q  <= '0;
    end else begin
      for (int b = 0; b < int'(BYTES); b++) begin
        if (we && win == WIN_STATUS && int'(bidx) == b)
          sts_q[b*8 +: 8] <= sts_q[b*8 +: 8] & ~wdata;
        if (we && win == WIN_ENABLE && int'(bidx) == b)
          en_q[b*8 +: 8] <= wdata;
      end
      if (hp_set)
        sts_q[HP_BIT] <= 1'b1;
    end
  end

  p_event_sets_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hp_set |=> sts_q[HP_BIT]);

  p_enable_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!we || win != WIN_ENABLE) |=> $stable(en_q));
endmodule

// File: rtl/hpg_slot_maps.sv
module hpg_slot_maps
  import hpg_pkg::*;
#(
  parameter int unsigned N  = SLOTS,
  parameter int unsigned AW = MAP_AW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AW-1:0]        addr,
  input  logic                 we,
  input  logic [N-1:0]         wdata,
  output logic [N-1:0]         rdata,
  input  logic                 ev_fire,
  input  logic [$clog2(N)-1:0] ev_slot,
  input  logic                 ev_insert
);
  logic [N-1:0] up_q, dn_q;

  always_comb begin
    if (addr == UP_OFF)      rdata = up_q;
    else if (addr == DN_OFF) rdata = dn_q;
    else                     rdata = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up_q <= '0;
      dn_q <= '0;
    end else if (ev_fire) begin
      up_q <= '0;
      dn_q <= '0;
      if (ev_insert) up_q[ev_slot] <= 1'b1;
      else           dn_q[ev_slot] <= 1'b1;
    end else if (we) begin
      if (addr == UP_OFF) up_q <= wdata;
      if (addr == DN_OFF) dn_q <= wdata;
    end
  end

  p_single_slot_after_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fire |=> $countones(up_q | dn_q) == 1);
endmodule

// File: rtl/hpg_eject_enc.sv
module hpg_eject_enc
  import hpg_pkg::*;
#(
  parameter int unsigned N = SLOTS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [N-1:0]         wdata,
  output logic                 req_valid,
  output logic [$clog2(N)-1:0] req_slot
);
  localparam int unsigned IW = $clog2(N);

  logic [IW-1:0] low_idx;
  logic          any_set;

  always_comb begin
    low_idx = '0;
    any_set = 1'b0;
    for (int i = 0; i < int'(N); i++) begin
      if (!any_set && wdata[i]) begin
        low_idx = IW'(i);
        any_set = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_slot  <= '0;
    end else begin
      req_valid <= we && any_set;
      if (we && any_set) req_slot <= low_idx;
    end
  end

  p_zero_mask_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wdata == '0) |=> !req_valid);

  p_strobe_from_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $past(we));
endmodule

// File: rtl/hotplug_event_block.sv
module hotplug_event_block
  import hpg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GPE_AW-1:0] gpe_addr,
  input  logic              gpe_we,
  input  logic [7:0]        gpe_wdata,
  output logic [7:0]        gpe_rdata,
  input  logic [MAP_AW-1:0] map_addr,
  input  logic              map_we,
  input  logic [SLOTS-1:0]  map_wdata,
  output logic [SLOTS-1:0]  map_rdata,
  input  logic              ej_we,
  input  logic [SLOTS-1:0]  ej_wdata,
  output logic [SLOTS-1:0]  ej_rdata,
  input  logic              evt_valid,
  output logic              evt_ready,
  input  logic [SLOT_W-1:0] evt_slot,
  input  logic              evt_insert,
  output logic              irq_pulse,
  output logic              eject_valid,
  output logic [SLOT_W-1:0] eject_slot
);
  logic [REG_BYTES*8-1:0] en_q;
  logic                   ev_fire;

  assign evt_ready = 1'b1;
  assign ev_fire   = evt_valid && evt_ready;
  assign ej_rdata  = '0;

  hpg_event_regs #(.BYTES(REG_BYTES), .AW(GPE_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(gpe_addr), .we(gpe_we),
    .wdata(gpe_wdata), .rdata(gpe_rdata), .hp_set(ev_fire), .en_q(en_q)
  );

  hpg_slot_maps #(.N(SLOTS), .AW(MAP_AW)) u_maps (
    .clk(clk), .rst_n(rst_n), .addr(map_addr), .we(map_we),
    .wdata(map_wdata), .rdata(map_rdata),
    .ev_fire(ev_fire), .ev_slot(evt_slot), .ev_insert(evt_insert)
  );

  hpg_eject_enc #(.N(SLOTS)) u_eject (
    .clk(clk), .rst_n(rst_n), .we(ej_we), .wdata(ej_wdata),
    .req_valid(eject_valid), .req_slot(eject_slot)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) irq_pulse <= 1'b0;
    else        irq_pulse <= ev_fire && en_q[HP_BIT];
  end

  p_irq_needs_enabled_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(ev_fire && en_q[HP_BIT]));

  p_ready_always_r11: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ready);
endmodule

// File: tb/hotplug_event_block_test.sv
module hotplug_event_block_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  gpe_addr = '0;
  logic        gpe_we = 1'b0;
  logic [7:0]  gpe_wdata = '0;
  logic [7:0]  gpe_rdata;
  logic [2:0]  map_addr = '0;
  logic        map_we = 1'b0;
  logic [31:0] map_wdata = '0;
  logic [31:0] map_rdata;
  logic        ej_we = 1'b0;
  logic [31:0] ej_wdata = '0;
  logic [31:0] ej_rdata;
  logic        evt_valid = 1'b0;
  logic        evt_ready;
  logic [4:0]  evt_slot = '0;
  logic        evt_insert = 1'b0;
  logic        irq_pulse;
  logic        eject_valid;
  logic [4:0]  eject_slot;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hotplug_event_block uut (.*);

  // op: 0 byte write, 1 byte read check, 2 map write, 3 map read check, 4 event
  // event data: [4:0] slot, [8] insert flag
  localparam int NV = 36;
  localparam logic [39:0] VEC [NV] = '{
    {4'd1, 1'b0, 3'd2, 32'h0000_0000},  // R1 reset
    {4'd1, 1'b0, 3'd1, 32'h0000_0000},  // R1 reset
    {4'd2, 1'b0, 3'd0, 32'h0000_0000},
    {4'd3, 1'b0, 3'd0, 32'h0000_0000},  // R1 reset
    {4'd0, 1'b0, 3'd2, 32'h0000_00A5},
    {4'd0, 1'b0, 3'd3, 32'h0000_0002},
    {4'd1, 1'b0, 3'd2, 32'h0000_00A5},  // R3
    {4'd1, 1'b0, 3'd3, 32'h0000_0002},  // R3
    {4'd0, 1'b0, 3'd3, 32'h0000_00FF},
    {4'd1, 1'b0, 3'd2, 32'h0000_00A5},  // R3 other byte kept
    {4'd1, 1'b0, 3'd3, 32'h0000_00FF},
    {4'd4, 1'b0, 3'd0, 32'h0000_0107},  // insert slot 7
    {4'd1, 1'b0, 3'd0, 32'h0000_0002},  // R6 status
    {4'd3, 1'b0, 3'd0, 32'h0000_0080},  // R6 up map
    {4'd3, 1'b0, 3'd4, 32'h0000_0000},
    {4'd4, 1'b0, 3'd0, 32'h0000_001F},  // remove slot 31
    {4'd3, 1'b0, 3'd0, 32'h0000_0000},  // R6 up cleared
    {4'd3, 1'b0, 3'd4, 32'h8000_0000},  // R6 down map
    {4'd0, 1'b0, 3'd1, 32'h0000_00FF},  // clear high byte only
    {4'd1, 1'b0, 3'd0, 32'h0000_0002},  // R2
    {4'd0, 1'b0, 3'd0, 32'h0000_0001},
    {4'd1, 1'b0, 3'd0, 32'h0000_0002},  // R2 bit1 untouched
    {4'd0, 1'b0, 3'd0, 32'h0000_0002},
    {4'd1, 1'b0, 3'd0, 32'h0000_0000},  // R2 cleared
    {4'd2, 1'b0, 3'd0, 32'hDEAD_BEEF},
    {4'd3, 1'b0, 3'd0, 32'hDEAD_BEEF},  // R5
    {4'd2, 1'b0, 3'd4, 32'h1234_5678},
    {4'd3, 1'b0, 3'd4, 32'h1234_5678},  // R5
    {4'd2, 1'b0, 3'd2, 32'hFFFF_FFFF},
    {4'd3, 1'b0, 3'd2, 32'h0000_0000},  // R4
    {4'd3, 1'b0, 3'd0, 32'hDEAD_BEEF},  // R4 no side effect
    {4'd0, 1'b0, 3'd5, 32'h0000_00FF},
    {4'd1, 1'b0, 3'd5, 32'h0000_0000},  // R4
    {4'd1, 1'b0, 3'd2, 32'h0000_00A5},  // R4 enable kept
    {4'd4, 1'b0, 3'd0, 32'h0000_0100},  // insert slot 0
    {4'd3, 1'b0, 3'd4, 32'h0000_0000}   // R6 down cleared
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic gw(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    gpe_addr = a; gpe_wdata = d; gpe_we = 1'b1;
    @(negedge clk);
    gpe_we = 1'b0;
  endtask

  task automatic mw(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    map_addr = a; map_wdata = d; map_we = 1'b1;
    @(negedge clk);
    map_we = 1'b0;
  endtask

  task automatic ev(input logic [4:0] s, input logic ins);
    @(negedge clk);
    evt_slot = s; evt_insert = ins; evt_valid = 1'b1;
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  task automatic ej(input logic [31:0] d);
    @(negedge clk);
    ej_wdata = d; ej_we = 1'b1;
    @(negedge clk);
    ej_we = 1'b0;
  endtask

  task automatic gr(input string req, input logic [2:0] a, input logic [7:0] e);
    gpe_addr = a; #1;
    check(req, {24'h0, gpe_rdata}, {24'h0, e});
  endtask

  task automatic mr(input string req, input logic [2:0] a, input logic [31:0] e);
    map_addr = a; #1;
    check(req, map_rdata, e);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 ready in reset", {31'h0, evt_ready}, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 irq reset", {31'h0, irq_pulse}, 32'h0);
    check("R8 eject reset", {31'h0, eject_valid}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [3:0]  op;
      logic [2:0]  a;
      logic [31:0] d;
      op = VEC[i][39:36];
      a  = VEC[i][34:32];
      d  = VEC[i][31:0];
      case (op)
        4'd0: gw(a, d[7:0]);
        4'd1: gr("R1-table byte read", a, d[7:0]);
        4'd2: mw(a, d);
        4'd3: mr("R5-table map read", a, d);
        default: ev(d[4:0], d[8]);
      endcase
      check("R7 no irq while disabled", {31'h0, irq_pulse}, 32'h0);
    end

    // R7: interrupt pulse when enable bit 1 set
    gw(3'd2, 8'h02);
    ev(5'd3, 1'b1);
    check("R7 irq high", {31'h0, irq_pulse}, 32'h1);
    @(negedge clk);
    check("R7 irq one cycle", {31'h0, irq_pulse}, 32'h0);
    gw(3'd2, 8'h00);
    ev(5'd4, 1'b0);
    check("R7 irq masked", {31'h0, irq_pulse}, 32'h0);

    // R8 / R9: eject conversion
    ej(32'h0000_0A00);
    check("R8 eject strobe", {31'h0, eject_valid}, 32'h1);
    check("R8 eject slot 9", {27'h0, eject_slot}, 32'd9);
    check("R8 eject read zero", ej_rdata, 32'h0);
    @(negedge clk);
    check("R8 strobe one cycle", {31'h0, eject_valid}, 32'h0);
    ej(32'h8000_0000);
    check("R8 eject slot 31", {27'h0, eject_slot}, 32'd31);
    ej(32'h0000_0000);
    check("R9 zero write silent", {31'h0, eject_valid}, 32'h0);

    // R10: event collides with status clear
    gw(3'd0, 8'hFF);
    gr("R10 status cleared before", 3'd0, 8'h00);
    @(negedge clk);
    evt_slot = 5'd12; evt_insert = 1'b1; evt_valid = 1'b1;
    gpe_addr = 3'd0; gpe_wdata = 8'h02; gpe_we = 1'b1;
    @(negedge clk);
    evt_valid = 1'b0; gpe_we = 1'b0;
    gr("R10 event beats clear", 3'd0, 8'h02);

    // R10: event collides with map write
    @(negedge clk);
    evt_slot = 5'd5; evt_insert = 1'b1; evt_valid = 1'b1;
    map_addr = 3'd0; map_wdata = 32'hFFFF_FFFF; map_we = 1'b1;
    @(negedge clk);
    evt_valid = 1'b0; map_we = 1'b0;
    mr("R10 event beats map write", 3'd0, 32'h0000_0020);
    check("R11 ready after run", {31'h0, evt_ready}, 32'h1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule